// File: doc/BRIEF.md
# Packed SIMD Lane Multiplier

This block multiplies matching lanes of two packed operand vectors and returns one lane-sized result per lane. A request carries two 128-bit operands, a 2-bit lane-size code, a carry-less mode bit, a wide-select bit and three 5-bit register indices (destination and two sources). The indices are not used for addressing; they are only checked for alignment. With wide-select low, only the low 64 bits are processed. With it high, both 64-bit halves are processed.

Integer lanes are 8, 16 or 32 bits wide. Each lane keeps only the low half of its double-width product, so signed and unsigned operands give the same result. In carry-less mode the 8-bit lanes are multiplied over GF(2): partial products are combined with XOR and the result is truncated to 8 bits. Illegal combinations raise an undefined flag and produce all-zero data.

A request is accepted when `inValid` and `inReady` are both high. Its result appears exactly two clock cycles later, whatever the operand values. A new request may be accepted on every cycle.

Top module: `lane_mul_unit`

## Requirements
- R1: The lane width is 8 shifted left by `sizeSel` (0→8, 1→16, 2→32 bits). Lane e takes bits [e*W+W-1 : e*W] of each 64-bit half, with lane 0 at the least significant bits.
- R2: With `opPoly`=0, each lane result is the low W bits of the product of the two W-bit lanes. Reading the operands as signed or as unsigned gives the same value.
- R3: With `opPoly`=1 and `sizeSel`=0, each 8-bit lane result is the low 8 bits of the carry-less product: shifted copies of one operand are combined by XOR.
- R4: `sizeSel`=3 sets `outUndef`.
- R5: `opPoly`=1 together with a nonzero `sizeSel` sets `outUndef`.
- R6: With `wideSel`=1, an odd value (bit 0 set) in any of `dstIdx`, `srcAIdx` or `srcBIdx` sets `outUndef`. With `wideSel`=0, odd indices are legal.
- R7: Whenever `outUndef` is high, `outData` is all zeros.
- R8: Once reset is released, `inReady` stays high. A request accepted at one rising edge has `outValid` high after the second rising edge that follows. This holds for back-to-back requests and does not depend on the data.
- R9: With `wideSel`=0, bits 127:64 of `outData` are zero, and bits 127:64 of the operands have no effect on the result.
- R10: During reset, and in any cycle with no result, `outValid`, `outUndef` and `outData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Block can accept a request |
| opPoly | input | 1 | Carry-less mode select |
| sizeSel | input | 2 | Lane size code |
| wideSel | input | 1 | Process both 64-bit halves |
| dstIdx | input | 5 | Destination register index (alignment check only) |
| srcAIdx | input | 5 | First source register index (alignment check only) |
| srcBIdx | input | 5 | Second source register index (alignment check only) |
| opA | input | 128 | First packed operand |
| opB | input | 128 | Second packed operand |
| outValid | output | 1 | Result present |
| outUndef | output | 1 | Request was illegal |
| outData | output | 128 | Packed lane results |

## Verification
Legality decode and lane arithmetic run in parallel, and an illegal request can sit in the output stage while a legal one is still in the multiply stage. The bench exercises this with streams of requests on consecutive cycles that alternate legal and illegal encodings, with wide and narrow requests mixed in. Each output cycle is compared with a model entry tagged by its issue cycle. The comparison shows that zeroed data and the undefined flag stay with their own request and never leak into the neighbouring one.

// File: rtl/lane_mul_pkg.sv
package lane_mul_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } laneSize_e;

  typedef struct packed {
    logic      load;
    logic      poly;
    laneSize_e size;
    logic      wide;
    logic      undef;
  } laneStrobe_t;
endpackage

// File: rtl/lane_mul_ctrl.sv
module lane_mul_ctrl
  import lane_mul_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             opPoly,
  input  logic [1:0]       sizeSel,
  input  logic             wideSel,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] srcBIdx,
  output logic             inReady,
  output laneStrobe_t      stb,
  output logic             outValid,
  output logic             outUndef
);
  logic readyQ;
  logic fire;
  logic badSize, badPoly, badAlign, isUndef;
  logic v1Q, u1Q, v2Q, u2Q;

  assign fire     = inValid & readyQ;
  assign badSize  = (sizeSel == SZ_BAD);
  assign badPoly  = opPoly & (sizeSel != SZ_BYTE);
  assign badAlign = wideSel & (dstIdx[0] | srcAIdx[0] | srcBIdx[0]);
  assign isUndef  = badSize | badPoly | badAlign;

  always_comb begin
    stb.load  = fire;
    stb.poly  = opPoly;
    stb.size  = laneSize_e'(sizeSel);
    stb.wide  = wideSel;
    stb.undef = isUndef;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      v1Q    <= 1'b0;
      u1Q    <= 1'b0;
      v2Q    <= 1'b0;
      u2Q    <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      v1Q    <= fire;
      u1Q    <= fire & isUndef;
      v2Q    <= v1Q;
      u2Q    <= u1Q;
    end
  end

  assign inReady  = readyQ;
  assign outValid = v2Q;
  assign outUndef = u2Q;
endmodule

// File: rtl/lane_mul_dpath.sv
module lane_mul_dpath
  import lane_mul_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int HALVES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  laneStrobe_t              stb,
  input  logic [HALF_W*HALVES-1:0] opA,
  input  logic [HALF_W*HALVES-1:0] opB,
  output logic [HALF_W*HALVES-1:0] outData
);
  localparam int DATA_W = HALF_W * HALVES;
  localparam int POLY_W = 8;
  localparam int POLY_N = HALF_W / POLY_W;

  function automatic logic [POLY_W-1:0] clmul(input logic [POLY_W-1:0] a,
                                               input logic [POLY_W-1:0] b);
    logic [POLY_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < POLY_W; i++) begin
      if (b[i]) acc = acc ^ (a << i);
    end
    return acc;
  endfunction

  laneStrobe_t        stQ;
  logic [DATA_W-1:0]  aQ, bQ, resQ;
  logic [DATA_W-1:0]  sel, nxt;
  logic [DATA_W-1:0]  wideMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ <= '0;
      aQ  <= '0;
      bQ  <= '0;
    end else begin
      stQ <= stb;
      aQ  <= opA;
      bQ  <= opB;
    end
  end

  for (genvar s = 0; s < 3; s++) begin : gSz
    localparam int W = 8 << s;
    localparam int N = HALF_W / W;
    logic [DATA_W-1:0] res;
    for (genvar h = 0; h < HALVES; h++) begin : gHalf
      for (genvar e = 0; e < N; e++) begin : gLane
        localparam int BASE = h * HALF_W + e * W;
        assign res[BASE +: W] = aQ[BASE +: W] * bQ[BASE +: W];
      end
    end
  end

  logic [DATA_W-1:0] polyRes;
  for (genvar h = 0; h < HALVES; h++) begin : gPolyHalf
    for (genvar e = 0; e < POLY_N; e++) begin : gPolyLane
      localparam int BASE = h * HALF_W + e * POLY_W;
      assign polyRes[BASE +: POLY_W] = clmul(aQ[BASE +: POLY_W], bQ[BASE +: POLY_W]);
    end
  end

  assign wideMask = {{(DATA_W-HALF_W){stQ.wide}}, {HALF_W{1'b1}}};

  always_comb begin
    case (stQ.size)
      SZ_BYTE: sel = stQ.poly ? polyRes : gSz[0].res;
      SZ_HALF: sel = gSz[1].res;
      SZ_WORD: sel = gSz[2].res;
      default: sel = '0;
    endcase
    if (!stQ.load || stQ.undef) nxt = '0;
    else                        nxt = sel & wideMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resQ <= '0;
    else       resQ <= nxt;
  end

  assign outData = resQ;
endmodule

// File: rtl/lane_mul_unit.sv
module lane_mul_unit
  import lane_mul_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int HALVES = 2,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic                     opPoly,
  input  logic [1:0]               sizeSel,
  input  logic                     wideSel,
  input  logic [IDX_W-1:0]         dstIdx,
  input  logic [IDX_W-1:0]         srcAIdx,
  input  logic [IDX_W-1:0]         srcBIdx,
  input  logic [HALF_W*HALVES-1:0] opA,
  input  logic [HALF_W*HALVES-1:0] opB,
  output logic                     outValid,
  output logic                     outUndef,
  output logic [HALF_W*HALVES-1:0] outData
);
  laneStrobe_t stb;

  lane_mul_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opPoly(opPoly),
    .sizeSel(sizeSel), .wideSel(wideSel), .dstIdx(dstIdx),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .inReady(inReady),
    .stb(stb), .outValid(outValid), .outUndef(outUndef)
  );

  lane_mul_dpath #(.HALF_W(HALF_W), .HALVES(HALVES)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .opA(opA), .opB(opB),
    .outData(outData)
  );
endmodule

// File: rtl/lane_mul_chk.sv
module lane_mul_chk #(
  parameter int HALF_W = 64,
  parameter int HALVES = 2,
  parameter int IDX_W  = 5
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     inReady,
  input logic                     opPoly,
  input logic [1:0]               sizeSel,
  input logic                     wideSel,
  input logic [IDX_W-1:0]         dstIdx,
  input logic [IDX_W-1:0]         srcAIdx,
  input logic [IDX_W-1:0]         srcBIdx,
  input logic [HALF_W*HALVES-1:0] opA,
  input logic [HALF_W*HALVES-1:0] opB,
  input logic                     outValid,
  input logic                     outUndef,
  input logic [HALF_W*HALVES-1:0] outData
);
  localparam int DATA_W = HALF_W * HALVES;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rstN)           age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd1) |-> inReady);

  // R8
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2) |-> (outValid == $past(inValid && inReady, 2)));

  // R7
  zero_on_undef_chk: assert property (@(posedge clk) disable iff (!rstN)
    outUndef |-> (outData == '0));

  // R9
  upper_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((age >= 2'd2) && $past(inValid && inReady && !wideSel, 2))
      |-> (outData[DATA_W-1:HALF_W] == '0));

  // R4
  bad_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((age >= 2'd2) && $past(inValid && inReady && (sizeSel == 2'd3), 2))
      |-> outUndef);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outUndef && (outData == '0)));
endmodule

bind lane_mul_unit lane_mul_chk #(.HALF_W(HALF_W), .HALVES(HALVES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .opPoly(opPoly), .sizeSel(sizeSel), .wideSel(wideSel), .dstIdx(dstIdx),
  .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .opA(opA), .opB(opB),
  .outValid(outValid), .outUndef(outUndef), .outData(outData)
);

// File: tb/lane_mul_unit_bench.sv
`timescale 1ns/1ps
module lane_mul_unit_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic         opPoly = 1'b0;
  logic [1:0]   sizeSel = 2'd0;
  logic         wideSel = 1'b0;
  logic [4:0]   dstIdx = '0, srcAIdx = '0, srcBIdx = '0;
  logic [127:0] opA = '0, opB = '0;
  logic         outValid, outUndef;
  logic [127:0] outData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int head   = 0;
  int tail   = 0;
  logic [127:0] expData  [0:511];
  logic         expUndef [0:511];
  int           expCyc   [0:511];
  string        expTag   [0:511];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_mul_unit u_lane_mul_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opPoly(opPoly), .sizeSel(sizeSel), .wideSel(wideSel), .dstIdx(dstIdx),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .opA(opA), .opB(opB),
    .outValid(outValid), .outUndef(outUndef), .outData(outData)
  );

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [128:0] model(logic poly, logic [1:0] sz, logic wide,
      logic [4:0] d, logic [4:0] n, logic [4:0] m, logic [127:0] a, logic [127:0] b);
    logic [127:0] res;
    int w, lanes, pos;
    logic [63:0] mask, al, bl, pr;
    longint sa, sb;
    if (sz == 2'd3 || (poly && sz != 2'd0) || (wide && (d[0] || n[0] || m[0])))
      return {1'b1, 128'd0};
    res   = '0;
    w     = 8 << sz;
    lanes = 64 / w;
    mask  = (64'd1 << w) - 64'd1;
    for (int h = 0; h < (wide ? 2 : 1); h++) begin
      for (int e = 0; e < lanes; e++) begin
        pos = h * 64 + e * w;
        al  = 64'(a >> pos) & mask;
        bl  = 64'(b >> pos) & mask;
        if (poly) begin
          pr = '0;
          for (int i = 0; i < 8; i++) if (bl[i]) pr = pr ^ (al << i);
        end else begin
          sa = al[w-1] ? longint'(al) - (longint'(1) <<< w) : longint'(al);
          sb = bl[w-1] ? longint'(bl) - (longint'(1) <<< w) : longint'(bl);
          pr = 64'(sa * sb);
        end
        res = res | (128'(pr & mask) << pos);
      end
    end
    return {1'b0, res};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // drive one request at a falling edge; returns at the next falling edge
  task automatic push(string tag, logic poly, logic [1:0] sz, logic wide,
      logic [4:0] d, logic [4:0] n, logic [4:0] m, logic [127:0] a, logic [127:0] b);
    logic [128:0] r;
    r = model(poly, sz, wide, d, n, m, a, b);
    inValid = 1'b1; opPoly = poly; sizeSel = sz; wideSel = wide;
    dstIdx = d; srcAIdx = n; srcBIdx = m; opA = a; opB = b;
    expData[tail]  = r[127:0];
    expUndef[tail] = r[128];
    expCyc[tail]   = cyc + 2;
    expTag[tail]   = tag;
    tail++;
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    inValid = 1'b0;
    repeat (4) @(negedge clk);
    check({tag, " all results returned"}, 128'(tail - head), 128'd0);
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (head == tail) begin
        check("R8 unexpected outValid", 128'd1, 128'd0);
      end else begin
        check({expTag[head], " timing"}, 128'(cyc), 128'(expCyc[head]));
        check({expTag[head], " undef"}, 128'(outUndef), 128'(expUndef[head]));
        check({expTag[head], " data"}, outData, expData[head]);
        head++;
      end
    end
  end

  task automatic t_reset();
    check("R10 reset outValid", 128'(outValid), 128'd0);
    check("R10 reset outUndef", 128'(outUndef), 128'd0);
    check("R10 reset outData", outData, 128'd0);
  endtask

  task automatic t_int(string tag, logic [1:0] sz);
    push({tag, " zeros"}, 0, sz, 1, 0, 2, 4, '0, rnd128());
    push({tag, " ones"}, 0, sz, 1, 6, 8, 10, '1, '1);
    push({tag, " msb pattern"}, 0, sz, 1, 0, 0, 0,
         {16{8'h80}} << (sz == 0 ? 0 : 0), sz == 2 ? {4{32'h8000_0000}} :
         sz == 1 ? {8{16'h8000}} : {16{8'h80}});
    push({tag, " ones x msb"}, 0, sz, 1, 2, 2, 2, '1, {16{8'h80}});
    for (int i = 0; i < 12; i++)
      push({tag, " random"}, 0, sz, i[0], 5'(2*i), 5'(2*i+2), 5'(4*i), rnd128(), rnd128());
    drain(tag);
    check({tag, " ready held"}, 128'(inReady), 128'd1);
  endtask

  task automatic t_poly();
    push("R3 poly ones", 1, 0, 1, 0, 0, 0, '1, '1);
    push("R3 poly msb", 1, 0, 1, 0, 0, 0, {16{8'h80}}, {16{8'h81}});
    push("R3 poly zero", 1, 0, 0, 1, 3, 5, '0, rnd128());
    for (int i = 0; i < 12; i++)
      push("R3 poly random", 1, 0, 1, 5'(2*i), 0, 2, rnd128(), rnd128());
    drain("R3");
  endtask

  task automatic t_illegal();
    push("R4 size3", 0, 3, 0, 0, 0, 0, rnd128(), rnd128());
    push("R4 size3 wide", 0, 3, 1, 0, 0, 0, '1, '1);
    push("R5 poly size1", 1, 1, 0, 0, 0, 0, rnd128(), rnd128());
    push("R5 poly size2", 1, 2, 1, 0, 0, 0, '1, '1);
    push("R6 odd dst", 0, 0, 1, 1, 0, 0, '1, '1);
    push("R6 odd srcA", 0, 1, 1, 0, 3, 0, '1, '1);
    push("R6 odd srcB", 1, 0, 1, 0, 0, 31, '1, '1);
    push("R6 odd narrow legal", 0, 2, 0, 1, 3, 31, rnd128(), rnd128());
    drain("R6");
  endtask

  task automatic t_narrow();
    logic [127:0] a, b;
    a = rnd128(); b = rnd128();
    push("R9 narrow base", 0, 1, 0, 4, 6, 8, a, b);
    push("R9 upper changed", 0, 1, 0, 4, 6, 8, {~a[127:64], a[63:0]}, {~b[127:64], b[63:0]});
    push("R9 poly upper", 1, 0, 0, 7, 9, 11, {64'hFFFF_FFFF_FFFF_FFFF, a[63:0]}, b);
    drain("R9");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++)
      push("R7 R8 stream", 1'(i % 5 == 3), 2'(i % 4), 1'(i % 3 != 0),
           5'(i), 5'(i + 1), 5'(2 * i), rnd128(), rnd128());
    drain("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", 128'(inReady), 128'd1);
    t_int("R1 R2 int8", 2'd0);
    t_int("R1 R2 int16", 2'd1);
    t_int("R1 R2 int32", 2'd2);
    t_poly();
    t_illegal();
    t_narrow();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule